// File: doc/BRIEF.md
# Flash Address Range Sequencer

This block walks a flash address pointer across a range inside one flash block while a self-programming command runs. Software loads a 12-bit start pointer and a 12-bit end (compare) value as high and low bytes over a small byte-wide register port. The high byte carries the 4-bit block number in its lower nibble, and its upper nibble must be zero. The low byte carries the address within the block.

On a start request the block checks the settings against the requested command. Write and verify use the compare low byte as their last address. Block erase must have it at 00H, and blank check must have it at FFH. If the settings are legal, the block raises busy. It then presents one address per cycle together with an operation strobe to the flash array, and steps the pointer until it equals the compare value. A one-cycle done pulse marks that last address. Illegal settings are refused and raise a sticky error flag.

The pointer has no defined value after reset. It is also spent at the end of each command, so both of its bytes must be written again before the next start is accepted.

Top module: `flash_range_seq`

## Requirements
- R1: A register write while idle stores `reg_wdata` as follows, by `reg_sel`: 0 is the pointer low byte, 1 is the pointer high byte (bits 3:0 are address bits 11:8), 2 is the compare low byte, and 3 is the compare high byte. While idle, `flash_addr` shows {pointer high[3:0], pointer low}.
- R2: After reset, busy, done, op_strobe and err are 0, both compare bytes are 00H, and the pointer counts as unwritten.
- R3: An accepted start (`cmd_start` high while idle) raises busy on the next cycle. While busy, op_strobe is high every cycle, and flash_addr begins at the pointer and rises by one each cycle.
- R4: done is high for exactly the one busy cycle in which flash_addr equals {compare high[3:0], compare low}. busy is low on the cycle after, and flash_addr keeps that end value.
- R5: A start is refused, with no error, unless both pointer bytes have been written since reset or since the last command ended.
- R6: If bits 7:4 of the pointer high byte or of the compare high byte are nonzero, a start is refused and err is set.
- R7: If the block number in compare high[3:0] differs from pointer high[3:0], a start is refused and err is set.
- R8: If the pointer low byte exceeds the compare low byte, a start is refused and err is set.
- R9: `cmd_op` values are 0 write, 1 block erase, 2 verify and 3 blank check. An erase whose compare low byte is not 00H, or a blank check whose compare low byte is not FFH, is refused and sets err.
- R10: Register writes and start requests that arrive while busy is high have no effect.
- R11: Once err is set, it stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write enable |
| reg_sel | input | 2 | Register select (see R1) |
| reg_wdata | input | 8 | Register write data |
| cmd_start | input | 1 | Start request, sampled while idle |
| cmd_op | input | 2 | Command code (see R9) |
| busy | output | 1 | Sequence running |
| done | output | 1 | Last address of the range is presented |
| op_strobe | output | 1 | One flash operation at flash_addr this cycle |
| flash_addr | output | 12 | Current pointer value |
| err | output | 1 | Sticky illegal-setting flag |

## Verification
Ranges of several lengths are run and told apart by the number of strobes and the end address. These include a single-address range (pointer equal to compare), a short verify, a full blank-check tail up to FFH, and an erase at 00H. Starts with no pointer write, with only one pointer byte written, and with a pointer left over from a finished command separate the rearm rule from the error rules. Each illegal setting is run from a fresh reset so that the sticky flag is traced to its own cause. Writes and starts injected during a blank-check run are followed by a verify. That verify's length shows whether the compare byte survived.

// File: rtl/flash_range_seq.sv
module flash_range_seq #(
  parameter int AW = 12,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [1:0]    reg_sel,
  input  logic [DW-1:0] reg_wdata,
  input  logic          cmd_start,
  input  logic [1:0]    cmd_op,
  output logic          busy,
  output logic          done,
  output logic          op_strobe,
  output logic [AW-1:0] flash_addr,
  output logic          err
);
  localparam int BW = AW - DW;
  localparam logic [1:0] OP_ERASE = 2'd1;
  localparam logic [1:0] OP_BLANK = 2'd3;

  logic [DW-1:0] p_hi, p_lo, c_hi, c_lo;
  logic          lo_set, hi_set, busy_q, err_q;

  wire [AW-1:0] ptr   = {p_hi[BW-1:0], p_lo};
  wire [AW-1:0] limit = {c_hi[BW-1:0], c_lo};
  wire          hit   = (ptr == limit);
  wire          armed = lo_set && hi_set;

  wire bad_hi    = (p_hi[DW-1:BW] != '0) || (c_hi[DW-1:BW] != '0);
  wire bad_blk   = (c_hi[BW-1:0] != p_hi[BW-1:0]);
  wire bad_order = (p_lo > c_lo);
  wire bad_end   = ((cmd_op == OP_ERASE) && (c_lo != '0)) ||
                   ((cmd_op == OP_BLANK) && (c_lo != '1));
  wire illegal   = bad_hi || bad_blk || bad_order || bad_end;

  wire try_go = !busy_q && cmd_start && armed;
  wire go     = try_go && !illegal;
  wire wr     = !busy_q && reg_we;

  assign busy       = busy_q;
  assign done       = busy_q && hit;
  assign op_strobe  = busy_q;
  assign flash_addr = ptr;
  assign err        = err_q;

  always_ff @(posedge clk) begin
    if (busy_q && !hit)
      {p_hi[BW-1:0], p_lo} <= ptr + 1'b1;
    else if (wr && reg_sel == 2'd0)
      p_lo <= reg_wdata;
    else if (wr && reg_sel == 2'd1)
      p_hi <= reg_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c_lo   <= '0;
      c_hi   <= '0;
      lo_set <= 1'b0;
      hi_set <= 1'b0;
      busy_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (wr && reg_sel == 2'd2) c_lo <= reg_wdata;
      if (wr && reg_sel == 2'd3) c_hi <= reg_wdata;
      if (wr && reg_sel == 2'd0) lo_set <= 1'b1;
      if (wr && reg_sel == 2'd1) hi_set <= 1'b1;
      if (try_go && illegal) err_q <= 1'b1;
      if (go) busy_q <= 1'b1;
      if (busy_q && hit) begin
        busy_q <= 1'b0;
        lo_set <= 1'b0;
        hi_set <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/flash_range_seq_chk.sv
module flash_range_seq_chk #(
  parameter int AW = 12,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_start,
  input logic          busy,
  input logic          done,
  input logic [AW-1:0] flash_addr,
  input logic          err
);
  assert_done_in_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  assert_step_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> (flash_addr == $past(flash_addr) + 1'b1));

  assert_same_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> (flash_addr[AW-1:DW] == $past(flash_addr[AW-1:DW])));

  assert_stop_at_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!busy && $stable(flash_addr)));

  assert_start_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_start));

  assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
endmodule

bind flash_range_seq flash_range_seq_chk #(.AW(AW), .DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .busy(busy),
  .done(done), .flash_addr(flash_addr), .err(err)
);

// File: tb/flash_range_seq_tb_top.sv
module flash_range_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [1:0] reg_sel = '0;
  logic [7:0] reg_wdata = '0;
  logic cmd_start = 1'b0;
  logic [1:0] cmd_op = '0;
  logic busy, done, op_strobe, err;
  logic [11:0] flash_addr;

  int n_checks = 0;
  int n_fail = 0;
  int strobes = 0;

  always #2 clk = ~clk;

  flash_range_seq dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .cmd_start(cmd_start), .cmd_op(cmd_op),
    .busy(busy), .done(done), .op_strobe(op_strobe),
    .flash_addr(flash_addr), .err(err)
  );

  // reference model
  logic [7:0] m_ph = 'x, m_pl = 'x, m_ch = '0, m_cl = '0;
  bit m_kh, m_kl, m_wh, m_wl, m_busy, m_err;

  function automatic bit m_bad(input logic [1:0] op);
    if (m_ph[7:4] != 0 || m_ch[7:4] != 0) return 1;
    if (m_ph[3:0] != m_ch[3:0]) return 1;
    if (m_pl > m_cl) return 1;
    if (op == 2'd1 && m_cl != 8'h00) return 1;
    if (op == 2'd3 && m_cl != 8'hFF) return 1;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 'x; m_pl = 'x; m_ch = '0; m_cl = '0;
      m_kh = 0; m_kl = 0; m_wh = 0; m_wl = 0; m_busy = 0; m_err = 0;
    end else if (m_busy) begin
      if ({m_ph[3:0], m_pl} == {m_ch[3:0], m_cl}) begin
        m_busy = 0; m_wh = 0; m_wl = 0;
      end else m_pl = m_pl + 8'd1;
    end else begin
      if (cmd_start && m_wh && m_wl) begin
        if (m_bad(cmd_op)) m_err = 1; else m_busy = 1;
      end
      if (reg_we) begin
        case (reg_sel)
          2'd0: begin m_pl = reg_wdata; m_kl = 1; m_wl = 1; end
          2'd1: begin m_ph = reg_wdata; m_kh = 1; m_wh = 1; end
          2'd2: m_cl = reg_wdata;
          default: m_ch = reg_wdata;
        endcase
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    bit e_done;
    e_done = m_busy && ({m_ph[3:0], m_pl} == {m_ch[3:0], m_cl});
    chk(busy == m_busy, "R3 busy", busy, m_busy);
    chk(op_strobe == m_busy, "R3 op_strobe", op_strobe, m_busy);
    chk(done == e_done, "R4 done", done, e_done);
    chk(err == m_err, "R6 err", err, m_err);
    if (m_kh && m_kl)
      chk(flash_addr == {m_ph[3:0], m_pl}, "R1 flash_addr", flash_addr, {m_ph[3:0], m_pl});
    if (op_strobe) strobes++;
  end

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk); reg_we = 1; reg_sel = s; reg_wdata = d; cmd_start = 0;
  endtask

  task automatic idle();
    @(negedge clk); reg_we = 0; cmd_start = 0;
  endtask

  task automatic setup(input logic [7:0] ph, pl, ch, cl);
    wr(2'd3, ch); wr(2'd2, cl); wr(2'd1, ph); wr(2'd0, pl); idle();
  endtask

  task automatic go_wait(input logic [1:0] op, output int n);
    int s0;
    s0 = strobes;
    @(negedge clk); reg_we = 0; cmd_start = 1; cmd_op = op;
    @(negedge clk); cmd_start = 0;
    for (int i = 0; i < 400; i++) begin
      if (!busy) break;
      @(negedge clk);
    end
    n = strobes - s0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; reg_we = 0; cmd_start = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
  endtask

  bit finished = 0;
  initial begin
    #400000;
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int n;
    do_reset();
    // R2: reset state
    idle();
    chk(!busy && !done && !op_strobe && !err, "R2 reset outputs", {busy, done, op_strobe, err}, 0);
    // R2 R5: start with unwritten pointer refused
    go_wait(2'd2, n);
    chk(n == 0 && !err, "R5 unwritten refused", n, 0);
    // R3 R4: verify 0x310..0x314
    setup(8'h03, 8'h10, 8'h03, 8'h14);
    go_wait(2'd2, n);
    chk(n == 5, "R4 verify length", n, 5);
    chk(flash_addr == 12'h314, "R4 end value", flash_addr, 12'h314);
    // R5: stale pointer refused
    go_wait(2'd2, n);
    chk(n == 0, "R5 stale pointer", n, 0);
    wr(2'd0, 8'h12); idle();
    go_wait(2'd2, n);
    chk(n == 0, "R5 one byte written", n, 0);
    wr(2'd1, 8'h03); idle();
    go_wait(2'd2, n);
    chk(n == 3, "R5 rearmed length", n, 3);
    // single address write range
    setup(8'h02, 8'h40, 8'h02, 8'h40);
    go_wait(2'd0, n);
    chk(n == 1, "R4 single address", n, 1);
    // R9 blank check with R10 writes during busy
    setup(8'h05, 8'hF0, 8'h05, 8'hFF);
    @(negedge clk); cmd_start = 1; cmd_op = 2'd3;
    @(negedge clk); cmd_start = 0; reg_we = 1; reg_sel = 2'd2; reg_wdata = 8'hF5;
    @(negedge clk); reg_sel = 2'd0; reg_wdata = 8'h00;
    @(negedge clk); reg_we = 0; cmd_start = 1; cmd_op = 2'd1;
    @(negedge clk); cmd_start = 0;
    for (int i = 0; i < 40 && busy; i++) @(negedge clk);
    chk(flash_addr == 12'h5FF, "R10 end after busy writes", flash_addr, 12'h5FF);
    wr(2'd1, 8'h05); wr(2'd0, 8'hF0); idle();
    go_wait(2'd2, n);
    chk(n == 16, "R10 compare kept", n, 16);
    // R9 erase single op
    setup(8'h07, 8'h00, 8'h07, 8'h00);
    go_wait(2'd1, n);
    chk(n == 1 && !err, "R9 erase", n, 1);
    // R6
    do_reset(); setup(8'h13, 8'h00, 8'h03, 8'h04);
    go_wait(2'd2, n);
    chk(n == 0 && err, "R6 pointer high nibble", err, 1);
    do_reset(); setup(8'h03, 8'h00, 8'h83, 8'h04);
    go_wait(2'd2, n);
    chk(n == 0 && err, "R6 compare high nibble", err, 1);
    // R7
    do_reset(); setup(8'h03, 8'h00, 8'h04, 8'h04);
    go_wait(2'd2, n);
    chk(n == 0 && err, "R7 block mismatch", err, 1);
    // R8
    do_reset(); setup(8'h03, 8'h20, 8'h03, 8'h10);
    go_wait(2'd0, n);
    chk(n == 0 && err, "R8 reversed range", err, 1);
    // R9 bad erase, bad blank
    do_reset(); setup(8'h03, 8'h00, 8'h03, 8'h01);
    go_wait(2'd1, n);
    chk(n == 0 && err, "R9 erase end", err, 1);
    do_reset(); setup(8'h03, 8'h00, 8'h03, 8'hFE);
    go_wait(2'd3, n);
    chk(n == 0 && err, "R9 blank end", err, 1);
    // R11: sticky through a later legal run
    wr(2'd2, 8'hFF); idle();
    go_wait(2'd3, n);
    chk(n == 256, "R11 legal run after error", n, 256);
    repeat (3) @(negedge clk);
    chk(err == 1, "R11 err stays", err, 1);
    do_reset(); idle();
    chk(err == 0, "R11 cleared by reset", err, 0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule